// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as seven fields: second, minute, hour, day of week, day of month, month and a three-digit year. A free-running 32.768 kHz enable pulse feeds a seconds divider. Once that divider has counted a full second of pulses, the fields move forward by one second. The advance carries through minutes, hours and days, and it follows real month lengths and the Gregorian leap-year rule.

Every field is presented at the outputs in BCD. Software changes the time through a small register write port. A control register holds a run bit. While run is clear, the clock is frozen and writes to the time fields are dropped. Setting run restarts the divider from a full count. Clearing run freezes the divider. A one-cycle strobe marks each second advance, so a downstream alarm comparator can sample the new time.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads second 00, minute 00, hour 00, weekday 0, day 01, month 01, year 000. Run and the strobe are both low.
- R2: With run set, the second advances after exactly TICKS_PER_SEC tick_en pulses (default 32768), counted from the cycle after run is set. tick_en pulses arriving while run is clear change nothing.
- R3: sec_tick_o is high for exactly one cycle, and the new field values are visible in that same cycle.
- R4: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R5: The day of week (0..6) increments on each day carry and wraps from 6 to 0.
- R6: Days run to the month's length: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 28 for month 02. The day then restarts at 01 and the month increments. Month 12 wraps to 01 and increments the year.
- R7: February has 29 days when the year is divisible by 4 and is either not a multiple of 100 or is a multiple of 400.
- R8: The year is three BCD digits: tens and ones in bits 7:0, hundreds in bits 11:8. It counts decimally through 099→100, and 999 wraps to 000.
- R9: Write address map: 0 control, 1 second, 2 minute, 3 hour, 4 weekday, 5 day, 6 month, 7 year. A time write (addresses 1..7) takes effect only while run is set. Otherwise it is ignored.
- R10: Control bit 0 is run. Writing 0 stops all advancing. Writing 1 when run was clear restarts the divider from a full second.
- R11: Written BCD values are kept as given, truncated to the field width (second and minute 7 bits, hour and day 6, weekday 3, month 5, year 12). A field above its limit restarts and carries at the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz base enable pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 12 | Write data (BCD for time fields) |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| wday_o | output | 3 | Day of week |
| mday_o | output | 6 | Day of month, BCD |
| mon_o | output | 5 | Month, BCD 01..12 |
| year_o | output | 12 | Year, three BCD digits |
| run_o | output | 1 | Run bit |
| sec_tick_o | output | 1 | One-cycle strobe after each second advance |

## Verification
A wrong divider count shows first. The distance from setting run to the first strobe is off, so it is visible one second after enabling, or one second after restarting. A wrong carry or month-length decision stays hidden until the exact boundary second. At that strobe the fields differ from the calendar, for example day 31 of April or February 29 in year 200. The bench therefore loads each boundary directly and compares the full time at the next strobe. A wrongly latched run state shows as a strobe, or a field change, while stopped.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [11:0] year;
        logic [4:0]  mon;
        logic [5:0]  mday;
        logic [2:0]  wday;
        logic [5:0]  hour;
        logic [6:0]  min;
        logic [6:0]  sec;
    } cal_t;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_SEC  = 3'd1,
        A_MIN  = 3'd2,
        A_HOUR = 3'd3,
        A_WDAY = 3'd4,
        A_MDAY = 3'd5,
        A_MON  = 3'd6,
        A_YEAR = 3'd7
    } reg_addr_e;

    localparam cal_t CAL_RESET = '{year: 12'h000, mon: 5'h01, mday: 6'h01,
                                   wday: 3'd0, hour: 6'h00, min: 7'h00, sec: 7'h00};

    // two BCD digits to binary (digits above 9 are taken at face value)
    function automatic logic [7:0] bcd2bin(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    // binary 0..99 to two BCD digits
    function automatic logic [7:0] bin2bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [10:0] bcd3bin(input logic [11:0] b);
        return 11'(b[11:8]) * 11'd100 + 11'(b[7:4]) * 11'd10 + 11'(b[3:0]);
    endfunction

    function automatic logic [11:0] bin2bcd3(input logic [10:0] v);
        logic [10:0] h;
        logic [10:0] r;
        logic [10:0] t;
        logic [10:0] o;
        h = v / 11'd100;
        r = v % 11'd100;
        t = r / 11'd10;
        o = r % 11'd10;
        return {h[3:0], t[3:0], o[3:0]};
    endfunction

    // Gregorian rule evaluated on the BCD digits directly
    function automatic logic leap_bcd(input logic [11:0] y);
        logic div4;
        if (y[4])
            div4 = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            div4 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        if (y[7:0] == 8'h00)
            return (y[11:8] == 4'd0) || (y[11:8] == 4'd4) || (y[11:8] == 4'd8);
        return div4;
    endfunction

endpackage

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic start_i,
    input  logic tick_i,
    output logic sec_evt_o
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_evt_o = 1'b0;
        if (start_i) begin
            cnt_d = FULL;
        end else if (run_i && tick_i) begin
            if (cnt_q <= CW'(1)) begin
                sec_evt_o = 1'b1;
                cnt_d     = FULL;
            end else begin
                cnt_d = cnt_q - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= FULL;
        else        cnt_q <= cnt_d;
    end

    // R2
    evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt_o |-> (run_i && tick_i));

    // R10
    frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  logic [4:0]  mon_i,
    input  logic [11:0] year_i,
    output logic [4:0]  days_o
);
    logic [7:0] mon_bin;

    always_comb begin
        mon_bin = bcd2bin({3'b000, mon_i});
        unique case (mon_bin)
            8'd2:                      days_o = leap_bcd(year_i) ? 5'd29 : 5'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   days_o = 5'd30;
            default:                   days_o = 5'd31;
        endcase
    end

endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
    import rtc_cal_pkg::*;
(
    input  cal_t       cur_i,
    input  logic [4:0] dim_i,
    output cal_t       nxt_o
);
    logic [7:0]  s_bin, m_bin, h_bin, d_bin, mo_bin, v8;
    logic [10:0] y_bin;
    logic [11:0] v12;
    logic        c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nxt_o  = cur_i;
        c_min  = 1'b0;
        c_hr   = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_yr   = 1'b0;
        v8     = '0;
        v12    = '0;
        s_bin  = bcd2bin({1'b0, cur_i.sec});
        m_bin  = bcd2bin({1'b0, cur_i.min});
        h_bin  = bcd2bin({2'b00, cur_i.hour});
        d_bin  = bcd2bin({2'b00, cur_i.mday});
        mo_bin = bcd2bin({3'b000, cur_i.mon});
        y_bin  = bcd3bin(cur_i.year);

        if (s_bin >= 8'd59) begin
            nxt_o.sec = '0;
            c_min     = 1'b1;
        end else begin
            v8        = bin2bcd(s_bin + 8'd1);
            nxt_o.sec = v8[6:0];
        end

        if (c_min) begin
            if (m_bin >= 8'd59) begin
                nxt_o.min = '0;
                c_hr      = 1'b1;
            end else begin
                v8        = bin2bcd(m_bin + 8'd1);
                nxt_o.min = v8[6:0];
            end
        end

        if (c_hr) begin
            if (h_bin >= 8'd23) begin
                nxt_o.hour = '0;
                c_day      = 1'b1;
            end else begin
                v8         = bin2bcd(h_bin + 8'd1);
                nxt_o.hour = v8[5:0];
            end
        end

        if (c_day) begin
            nxt_o.wday = (cur_i.wday >= 3'd6) ? 3'd0 : cur_i.wday + 3'd1;
            if (d_bin >= 8'(dim_i)) begin
                nxt_o.mday = 6'h01;
                c_mon      = 1'b1;
            end else begin
                v8         = bin2bcd(d_bin + 8'd1);
                nxt_o.mday = v8[5:0];
            end
        end

        if (c_mon) begin
            if (mo_bin >= 8'd12) begin
                nxt_o.mon = 5'h01;
                c_yr      = 1'b1;
            end else begin
                v8        = bin2bcd(mo_bin + 8'd1);
                nxt_o.mon = v8[4:0];
            end
        end

        if (c_yr) begin
            if (y_bin >= 11'd999) begin
                nxt_o.year = 12'h000;
            end else begin
                v12        = bin2bcd3(y_bin + 11'd1);
                nxt_o.year = v12;
            end
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [11:0] reg_wdata,
    output logic [6:0]  sec_o,
    output logic [6:0]  min_o,
    output logic [5:0]  hour_o,
    output logic [2:0]  wday_o,
    output logic [5:0]  mday_o,
    output logic [4:0]  mon_o,
    output logic [11:0] year_o,
    output logic        run_o,
    output logic        sec_tick_o
);
    typedef struct packed {
        cal_t cal;
        logic run;
        logic tick;
    } st_t;

    st_t        st_d, st_q;
    cal_t       cal_next;
    logic [4:0] dim;
    logic       sec_evt;
    logic       start;
    logic       wr_ctrl;
    logic       wr_time;
    reg_addr_e  addr;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_ctrl = reg_wr && (addr == A_CTRL);
    assign wr_time = reg_wr && (addr != A_CTRL) && st_q.run;
    assign start   = wr_ctrl && reg_wdata[0] && !st_q.run;

    rtc_sec_div #(.TICKS(TICKS_PER_SEC)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run),
        .start_i  (start),
        .tick_i   (tick_en),
        .sec_evt_o(sec_evt)
    );

    rtc_month_len u_mlen (
        .mon_i (st_q.cal.mon),
        .year_i(st_q.cal.year),
        .days_o(dim)
    );

    rtc_date_step u_step (
        .cur_i(st_q.cal),
        .dim_i(dim),
        .nxt_o(cal_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = sec_evt;
        if (sec_evt) st_d.cal = cal_next;
        if (wr_ctrl) st_d.run = reg_wdata[0];
        if (wr_time) begin
            unique case (addr)
                A_SEC:   st_d.cal.sec  = reg_wdata[6:0];
                A_MIN:   st_d.cal.min  = reg_wdata[6:0];
                A_HOUR:  st_d.cal.hour = reg_wdata[5:0];
                A_WDAY:  st_d.cal.wday = reg_wdata[2:0];
                A_MDAY:  st_d.cal.mday = reg_wdata[5:0];
                A_MON:   st_d.cal.mon  = reg_wdata[4:0];
                A_YEAR:  st_d.cal.year = reg_wdata[11:0];
                default: st_d.cal      = st_d.cal;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cal  <= CAL_RESET;
            st_q.run  <= 1'b0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o      = st_q.cal.sec;
    assign min_o      = st_q.cal.min;
    assign hour_o     = st_q.cal.hour;
    assign wday_o     = st_q.cal.wday;
    assign mday_o     = st_q.cal.mday;
    assign mon_o      = st_q.cal.mon;
    assign year_o     = st_q.cal.year;
    assign run_o      = st_q.run;
    assign sec_tick_o = st_q.tick;

    // R9
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != 3'd0 && !run_o) |=> $stable(st_q.cal));

    // R3
    tick_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |-> $past(run_o));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && !$past(reg_wr) && $past(sec_o) == 7'h59) |-> (sec_o == 7'h00));

    // R5
    wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && !$past(reg_wr) && $past(wday_o) == 3'd6 && $past(hour_o) == 6'h23
         && $past(min_o) == 7'h59 && $past(sec_o) == 7'h59) |-> (wday_o == 3'd0));

    // R10
    no_tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !$past(run_o)) |-> !sec_tick_o);

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
    import rtc_cal_pkg::*;

    localparam int TPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [11:0] reg_wdata = 12'h000;
    logic [6:0]  sec_o, min_o;
    logic [5:0]  hour_o, mday_o;
    logic [2:0]  wday_o;
    logic [4:0]  mon_o;
    logic [11:0] year_o;
    logic        run_o, sec_tick_o;

    always #5 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
        .run_o(run_o), .sec_tick_o(sec_tick_o)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [45:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [45:0] now_t();
        return {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
    endfunction

    function automatic logic [45:0] mk(input logic [11:0] y, input logic [4:0] mo,
                                       input logic [5:0] d, input logic [2:0] w,
                                       input logic [5:0] h, input logic [6:0] mi,
                                       input logic [6:0] s);
        return {y, mo, d, w, h, mi, s};
    endfunction

    task automatic check(input string tag, input logic [45:0] act, input logic [45:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_all(input logic [11:0] y, input logic [4:0] mo, input logic [5:0] d,
                           input logic [2:0] w, input logic [5:0] h, input logic [6:0] mi,
                           input logic [6:0] s);
        wr(3'd7, y);
        wr(3'd6, 12'(mo));
        wr(3'd5, 12'(d));
        wr(3'd4, 12'(w));
        wr(3'd3, 12'(h));
        wr(3'd2, 12'(mi));
        wr(3'd1, 12'(s));
    endtask

    // driver: load a time, queue the expected time for the next strobe, run
    task automatic step(input string tag, input logic [45:0] start_t, input logic [45:0] exp);
        tick_en = 1'b0;
        set_all(start_t[45:34], start_t[33:29], start_t[28:23], start_t[22:20],
                start_t[19:14], start_t[13:7], start_t[6:0]);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic measure(input string tag);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sec_tick_o && n < 100);
        check(tag, 46'(n), 46'(TPS));
    endtask

    // monitor: compare queued expectations at each strobe
    always @(negedge clk) begin
        if (rst_n && sec_tick_o && exp_q.size() > 0) begin
            check(tag_q.pop_front(), now_t(), exp_q.pop_front());
        end
    end

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [45:0] snap;
        int seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fields", now_t(), mk(12'h000, 5'h01, 6'h01, 3'd0, 6'h00, 7'h00, 7'h00));
        check("R1 run/strobe", 46'({run_o, sec_tick_o}), 46'(0));

        // R9 time write while stopped is dropped; R2 ticks while stopped ignored
        tick_en = 1'b1;
        wr(3'd1, 12'h030);
        repeat (20) @(negedge clk);
        check("R9 write while stopped", now_t(), mk(12'h000, 5'h01, 6'h01, 3'd0, 6'h00, 7'h00, 7'h00));
        check("R2 ticks while stopped", 46'(sec_tick_o), 46'(0));

        // R2 divider count from enable, R3 strobe alignment and width
        wr(3'd0, 12'h001);
        measure("R2 ticks to first second");
        check("R3 fields with strobe", now_t(), mk(12'h000, 5'h01, 6'h01, 3'd0, 6'h00, 7'h00, 7'h01));
        @(negedge clk);
        check("R3 strobe one cycle", 46'(sec_tick_o), 46'(0));

        // R4 carries
        step("R4 minute carry", mk(12'h000, 5'h01, 6'h01, 3'd2, 6'h00, 7'h12, 7'h59),
                                mk(12'h000, 5'h01, 6'h01, 3'd2, 6'h00, 7'h13, 7'h00));
        step("R4 hour carry",   mk(12'h123, 5'h05, 6'h17, 3'd3, 6'h10, 7'h59, 7'h59),
                                mk(12'h123, 5'h05, 6'h17, 3'd3, 6'h11, 7'h00, 7'h00));
        // R5 R6 R8 full rollover at year end
        step("R5 R6 R8 year end", mk(12'h199, 5'h12, 6'h31, 3'd6, 6'h23, 7'h59, 7'h59),
                                  mk(12'h200, 5'h01, 6'h01, 3'd0, 6'h00, 7'h00, 7'h00));
        // R6 month lengths
        step("R6 april end",  mk(12'h201, 5'h04, 6'h30, 3'd1, 6'h23, 7'h59, 7'h59),
                              mk(12'h201, 5'h05, 6'h01, 3'd2, 6'h00, 7'h00, 7'h00));
        step("R6 jan end",    mk(12'h201, 5'h01, 6'h31, 3'd4, 6'h23, 7'h59, 7'h59),
                              mk(12'h201, 5'h02, 6'h01, 3'd5, 6'h00, 7'h00, 7'h00));
        step("R6 jan 30",     mk(12'h201, 5'h01, 6'h30, 3'd3, 6'h23, 7'h59, 7'h59),
                              mk(12'h201, 5'h01, 6'h31, 3'd4, 6'h00, 7'h00, 7'h00));
        // R7 leap rule
        step("R7 year 200 not leap", mk(12'h200, 5'h02, 6'h28, 3'd4, 6'h23, 7'h59, 7'h59),
                                     mk(12'h200, 5'h03, 6'h01, 3'd5, 6'h00, 7'h00, 7'h00));
        step("R7 year 400 leap",     mk(12'h400, 5'h02, 6'h28, 3'd4, 6'h23, 7'h59, 7'h59),
                                     mk(12'h400, 5'h02, 6'h29, 3'd5, 6'h00, 7'h00, 7'h00));
        step("R7 year 400 feb 29",   mk(12'h400, 5'h02, 6'h29, 3'd5, 6'h23, 7'h59, 7'h59),
                                     mk(12'h400, 5'h03, 6'h01, 3'd6, 6'h00, 7'h00, 7'h00));
        step("R7 year 024 leap",     mk(12'h024, 5'h02, 6'h28, 3'd0, 6'h23, 7'h59, 7'h59),
                                     mk(12'h024, 5'h02, 6'h29, 3'd1, 6'h00, 7'h00, 7'h00));
        step("R7 year 023 common",   mk(12'h023, 5'h02, 6'h28, 3'd0, 6'h23, 7'h59, 7'h59),
                                     mk(12'h023, 5'h03, 6'h01, 3'd1, 6'h00, 7'h00, 7'h00));
        // R8 year digits
        step("R8 999 wrap", mk(12'h999, 5'h12, 6'h31, 3'd3, 6'h23, 7'h59, 7'h59),
                            mk(12'h000, 5'h01, 6'h01, 3'd4, 6'h00, 7'h00, 7'h00));
        step("R8 099 carry", mk(12'h099, 5'h12, 6'h31, 3'd2, 6'h23, 7'h59, 7'h59),
                             mk(12'h100, 5'h01, 6'h01, 3'd3, 6'h00, 7'h00, 7'h00));

        // R11 stored as given, truncated to field width
        tick_en = 1'b0;
        wr(3'd1, 12'h07F);
        check("R11 sec readback", 46'(sec_o), 46'(7'h7F));
        wr(3'd3, 12'hFFF);
        check("R11 hour truncation", 46'(hour_o), 46'(6'h3F));
        step("R11 out of range second", mk(12'h010, 5'h03, 6'h03, 3'd1, 6'h05, 7'h20, 7'h7F),
                                        mk(12'h010, 5'h03, 6'h03, 3'd1, 6'h05, 7'h21, 7'h00));

        // R10 stop freezes, restart reloads full count
        tick_en = 1'b0;
        wr(3'd0, 12'h000);
        tick_en = 1'b1;
        snap = now_t();
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sec_tick_o) seen++;
        end
        check("R10 no strobe while stopped", 46'(seen), 46'(0));
        check("R10 time frozen", now_t(), snap);
        wr(3'd2, 12'h033);
        check("R9 minute write while stopped", now_t(), snap);
        wr(3'd0, 12'h001);
        measure("R10 restart full count");

        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule